// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 3-bit test-select code. Software or board logic can set them in two ways. In the first, parallel pins drive the values straight through and are frozen when a mode line rises. In the second, a 14-bit frame is shifted in bit by bit on a slow serial clock and then committed.

All serial and mode lines are asynchronous to the block. Each one passes through a two-flop synchronizer on a fast system clock, and the block finds their edges by comparing against one more registered copy. The parallel data pins are synchronized the same way. The system clock must run at least four times faster than the serial clock, and every serial level must last at least two system clocks. The block also drives the oldest shift-register bit out, so several loaders can be chained. A flag reports whether the feedback value lies in the range where the loop can lock.

Top module: `synth_cfg_loader`

## Requirements
- R1: During a synchronous reset (`rst` high), the shift register and all outputs are cleared to zero. `fb_ok` is low.
- R2: A change on any input affects the outputs at the third rising edge of `clk` after that change, and not before.
- R3: While synchronized `hold_par` is low, `div_fb` follows `par_fb`, `div_out` follows `par_out`, and `tsel` is forced to 3'b000.
- R4: When `hold_par` goes high, the parallel values are kept. Later changes on `par_fb` and `par_out` then have no effect.
- R5: While `hold_par` is high and `ser_commit` is low, each rising edge of `ser_clk` shifts `ser_din` into bit 0 of the 14-bit shift register, and `div_fb`, `div_out` and `tsel` do not change. The frame is sent first bit first in the order T2, T1, T0, N1, N0, M8 down to M0.
- R6: `ser_dout` is bit 13 of the shift register, which is the oldest bit. After a full frame it equals the first bit sent.
- R7: A rising edge of `ser_commit` while `hold_par` is high loads the register as follows: `tsel` takes bits 13:11, `div_out` takes bits 10:9, and `div_fb` takes bits 8:0.
- R8: A falling edge of `ser_commit` leaves `div_fb`, `div_out` and `tsel` unchanged.
- R9: While `ser_commit` stays high, each rising edge of `ser_clk` shifts the register. `div_fb` then takes the new bits 8:0, and `div_out` and `tsel` stay the same.
- R10: If a `ser_commit` rise and a `ser_clk` rise are detected at the same edge, the commit of R7 takes place and the shift register does not shift.
- R11: `fb_ok` is high exactly when 125 <= `div_fb` <= 350.
- R12: Rising edges of `ser_clk` while `hold_par` is low leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_par | input | 1 | Low: parallel pins pass through; high: hold or serial mode |
| ser_clk | input | 1 | Serial clock, shifts on its rising edge |
| ser_din | input | 1 | Serial data |
| ser_commit | input | 1 | Serial commit strobe |
| par_fb | input | 9 | Parallel feedback divide value |
| par_out | input | 2 | Parallel output divide code |
| div_fb | output | 9 | Feedback divide value |
| div_out | output | 2 | Output divide code |
| tsel | output | 3 | Test-select code |
| ser_dout | output | 1 | Oldest shift-register bit, used for chaining |
| fb_ok | output | 1 | Feedback value is inside the lock range |

## Verification
Two serial events can be detected at the same system-clock edge: a commit rise and a serial-clock rise. The bench raises `ser_commit` and `ser_clk` together, with `ser_din` set to 1. It then expects the fields of the frame sent just before that moment, and a `ser_dout` that did not move. A behavioural model follows the same synchronizer latency and is compared with the outputs on every clock. Any extra shift would show up both in `div_fb` and in `ser_dout`.

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int MW   = 9,
  parameter int NW   = 2,
  parameter int TW   = 3,
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_par,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          ser_commit,
  input  logic [MW-1:0] par_fb,
  input  logic [NW-1:0] par_out,
  output logic [MW-1:0] div_fb,
  output logic [NW-1:0] div_out,
  output logic [TW-1:0] tsel,
  output logic          ser_dout,
  output logic          fb_ok
);
  localparam int FW = MW + NW + TW;
  localparam int PW = MW + NW;

  // control lines packed as {hold, commit, sclk}
  logic [2:0]    ctl_a, ctl_b, ctl_q;
  logic          din_a, din_b;
  logic [PW-1:0] par_a, par_b;
  logic [FW-1:0] sr;

  logic hold_s, commit_s, sclk_rise, commit_rise, shift_en, pass_en;
  logic [FW-1:0] sr_next;

  assign hold_s      = ctl_b[2];
  assign commit_s    = ctl_b[1];
  assign sclk_rise   = ctl_b[0] & ~ctl_q[0];
  assign commit_rise = commit_s & ~ctl_q[1];
  assign shift_en    = hold_s & ~commit_s & sclk_rise;
  assign pass_en     = hold_s & commit_s & ctl_q[1] & sclk_rise;
  assign sr_next     = {sr[FW-2:0], din_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a   <= '0;
      ctl_b   <= '0;
      ctl_q   <= '0;
      din_a   <= 1'b0;
      din_b   <= 1'b0;
      par_a   <= '0;
      par_b   <= '0;
      sr      <= '0;
      div_fb  <= '0;
      div_out <= '0;
      tsel    <= '0;
    end else begin
      ctl_a <= {hold_par, ser_commit, ser_clk};
      ctl_b <= ctl_a;
      ctl_q <= ctl_b;
      din_a <= ser_din;
      din_b <= din_a;
      par_a <= {par_fb, par_out};
      par_b <= par_a;
      if (shift_en || pass_en) sr <= sr_next;
      if (!hold_s) begin
        div_fb  <= par_b[PW-1:NW];
        div_out <= par_b[NW-1:0];
        tsel    <= '0;
      end else if (commit_rise) begin
        {tsel, div_out, div_fb} <= sr;
      end else if (pass_en) begin
        div_fb <= sr_next[MW-1:0];
      end
    end
  end

  assign ser_dout = sr[FW-1];
  assign fb_ok    = (int'(div_fb) >= M_LO) && (int'(div_fb) <= M_HI);

endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  parameter int FW = MW + NW + TW
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    ctl_b,
  input logic [2:0]    ctl_q,
  input logic [FW-1:0] sr,
  input logic [MW-1:0] div_fb,
  input logic [NW-1:0] div_out,
  input logic [TW-1:0] tsel,
  input logic          ser_dout
);
  logic c_hold, c_crise, c_cfall, c_krise;
  assign c_hold  = ctl_b[2];
  assign c_crise = ctl_b[1] & ~ctl_q[1];
  assign c_cfall = ~ctl_b[1] & ctl_q[1];
  assign c_krise = ctl_b[0] & ~ctl_q[0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (div_fb == '0 && div_out == '0 && tsel == '0 && sr == '0));

  assert_par_tsel_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !c_hold |=> tsel == '0);

  assert_shift_keeps_fields_R5: assert property (@(posedge clk) disable iff (rst)
    (c_hold && !ctl_b[1] && c_krise) |=> ($stable(div_fb) && $stable(div_out) && $stable(tsel)));

  assert_dout_oldest_R6: assert property (@(posedge clk) disable iff (rst)
    (c_hold && !ctl_b[1] && c_krise) |=> ser_dout == $past(sr[FW-2]));

  assert_commit_load_R7: assert property (@(posedge clk) disable iff (rst)
    (c_hold && c_crise) |=> {tsel, div_out, div_fb} == $past(sr));

  assert_fall_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (c_hold && c_cfall) |=> ($stable(div_fb) && $stable(div_out) && $stable(tsel)));

  assert_coincide_no_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (c_hold && c_crise && c_krise) |=> $stable(sr));

  assert_par_no_shift_R12: assert property (@(posedge clk) disable iff (rst)
    !c_hold |=> $stable(sr));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(.MW(MW), .NW(NW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .ctl_b(ctl_b), .ctl_q(ctl_q), .sr(sr),
  .div_fb(div_fb), .div_out(div_out), .tsel(tsel), .ser_dout(ser_dout)
);

// File: tb/test_synth_cfg_loader.sv
`timescale 1ns/1ps
module test_synth_cfg_loader;
  logic clk = 1'b0, rst = 1'b1;
  logic hold_par = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, ser_commit = 1'b0;
  logic [8:0] par_fb = '0;
  logic [1:0] par_out = '0;
  logic [8:0] div_fb;
  logic [1:0] div_out;
  logic [2:0] tsel;
  logic ser_dout, fb_ok;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  synth_cfg_loader i_synth_cfg_loader (
    .clk(clk), .rst(rst), .hold_par(hold_par), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_commit(ser_commit), .par_fb(par_fb), .par_out(par_out), .div_fb(div_fb),
    .div_out(div_out), .tsel(tsel), .ser_dout(ser_dout), .fb_ok(fb_ok));

  // behavioural model: input history, bit queue, integer fields
  bit h_hold[3], h_com[3], h_sck[3], h_din[3];
  int h_pf[3], h_po[3];
  bit mq[$];
  int mm, mn, mt;

  function automatic int qfield(int lo, int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(mq[lo + i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        h_hold[i] = 0; h_com[i] = 0; h_sck[i] = 0; h_din[i] = 0; h_pf[i] = 0; h_po[i] = 0;
      end
      mq.delete();
      for (int i = 0; i < 14; i++) mq.push_back(1'b0);
      mm = 0; mn = 0; mt = 0;
    end else begin
      bit krise;
      krise = h_sck[1] && !h_sck[2];
      if (h_hold[1] && krise && (!h_com[1] || h_com[2])) begin
        mq.push_back(h_din[1]);
        void'(mq.pop_front());
      end
      if (!h_hold[1]) begin
        mm = h_pf[1]; mn = h_po[1]; mt = 0;
      end else if (h_com[1] && !h_com[2]) begin
        mt = qfield(0, 3); mn = qfield(3, 2); mm = qfield(5, 9);
      end else if (h_com[1] && krise) begin
        mm = qfield(5, 9);
      end
      for (int i = 2; i > 0; i--) begin
        h_hold[i] = h_hold[i-1]; h_com[i] = h_com[i-1]; h_sck[i] = h_sck[i-1];
        h_din[i] = h_din[i-1]; h_pf[i] = h_pf[i-1]; h_po[i] = h_po[i-1];
      end
      h_hold[0] = hold_par; h_com[0] = ser_commit; h_sck[0] = ser_clk;
      h_din[0] = ser_din; h_pf[0] = int'(par_fb); h_po[0] = int'(par_out);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model div_fb", int'(div_fb), mm);
      chk(cur_req, "model div_out", int'(div_out), mn);
      chk(cur_req, "model tsel", int'(tsel), mt);
      chk(cur_req, "model ser_dout", int'(ser_dout), int'(mq[0]));
      chk("R11", "model fb_ok", int'(fb_ok), (mm >= 125 && mm <= 350) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(bit b);
    ser_din = b; tick(3);
    ser_clk = 1'b1; tick(3);
    ser_clk = 1'b0;
  endtask

  task automatic send(int t, int n, int m);
    logic [13:0] f;
    f = {t[2:0], n[1:0], m[8:0]};
    for (int i = 13; i >= 0; i--) sclk_pulse(f[i]);
    tick(3);
  endtask

  initial begin
    tick(4);
    chk("R1", "reset div_fb", int'(div_fb), 0);
    chk("R1", "reset tsel", int'(tsel), 0);
    chk("R1", "reset fb_ok", int'(fb_ok), 0);
    rst = 1'b0;
    tick(1);
    chk("R1", "after reset ser_dout", int'(ser_dout), 0);

    cur_req = "R3";
    par_fb = 9'd200; par_out = 2'd2; tick(5);
    chk("R3", "par div_fb", int'(div_fb), 200);
    chk("R3", "par div_out", int'(div_out), 2);
    chk("R11", "fb_ok at 200", int'(fb_ok), 1);

    cur_req = "R2";
    par_fb = 9'd300; tick(2);
    chk("R2", "no change before 3rd edge", int'(div_fb), 200);
    tick(1);
    chk("R2", "change at 3rd edge", int'(div_fb), 300);

    cur_req = "R4";
    hold_par = 1'b1; tick(4);
    par_fb = 9'd17; par_out = 2'd0; tick(5);
    chk("R4", "held div_fb", int'(div_fb), 300);
    chk("R4", "held div_out", int'(div_out), 2);

    cur_req = "R5";
    send(5, 1, 124);
    chk("R5", "fields unchanged by shift", int'(div_fb), 300);
    chk("R6", "ser_dout first bit", int'(ser_dout), 1);

    cur_req = "R7";
    ser_commit = 1'b1; tick(4);
    chk("R7", "commit tsel", int'(tsel), 5);
    chk("R7", "commit div_out", int'(div_out), 1);
    chk("R7", "commit div_fb", int'(div_fb), 124);
    chk("R11", "fb_ok at 124", int'(fb_ok), 0);

    cur_req = "R9";
    sclk_pulse(1'b1); tick(3);
    chk("R9", "pass div_fb", int'(div_fb), 249);
    sclk_pulse(1'b0); tick(3);
    chk("R9", "pass div_fb second", int'(div_fb), 498);
    chk("R9", "pass tsel kept", int'(tsel), 5);

    cur_req = "R8";
    ser_commit = 1'b0; tick(5);
    chk("R8", "fall keeps div_fb", int'(div_fb), 498);
    chk("R8", "fall keeps div_out", int'(div_out), 1);

    cur_req = "R10";
    send(2, 3, 350);
    ser_din = 1'b1; ser_clk = 1'b1; ser_commit = 1'b1; tick(5);
    chk("R10", "coincide div_fb", int'(div_fb), 350);
    chk("R10", "coincide tsel", int'(tsel), 2);
    chk("R10", "no shift ser_dout", int'(ser_dout), 0);
    chk("R11", "fb_ok at 350", int'(fb_ok), 1);
    ser_clk = 1'b0; tick(3);
    ser_commit = 1'b0; tick(4);

    cur_req = "R11";
    hold_par = 1'b0; par_fb = 9'd351; par_out = 2'd0; tick(5);
    chk("R11", "fb_ok at 351", int'(fb_ok), 0);
    par_fb = 9'd125; tick(5);
    chk("R11", "fb_ok at 125", int'(fb_ok), 1);
    chk("R3", "tsel forced zero", int'(tsel), 0);

    cur_req = "R12";
    for (int i = 0; i < 4; i++) sclk_pulse(1'b1);
    tick(3);
    chk("R12", "ser_dout unchanged", int'(ser_dout), 0);
    hold_par = 1'b1; tick(4);
    ser_commit = 1'b1; tick(4);
    chk("R12", "old frame tsel", int'(tsel), 2);
    chk("R12", "old frame div_out", int'(div_out), 3);
    chk("R12", "old frame div_fb", int'(div_fb), 350);
    ser_commit = 1'b0; tick(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule